// File: doc/BRIEF.md
# Host Controller Interrupt Gate

This block sits between the event flags of a host controller and the interrupt line it raises. The controller pulses one input per source when something happens. That sets a sticky status flag. Software owns a three-bit enable register and clears status flags by writing ones to them. An interrupt goes out only for a source whose enable bit and status flag are both set.

The sources differ in timing. A port change raises the interrupt directly. Transfer completion and transfer error wait for a pulse on the threshold tick input. At that point the request is captured, and it stays active until software clears the status flag or drops the enable.

Which sources are immediate and which are deferred is a parameter. By default, source 0 (transfer complete) and source 1 (transfer error) are deferred, and source 2 (port change) is immediate.

Top module: `host_irq_gate`

## Requirements
- R1: After reset the enable register, the status flags and `irq` are all zero.
- R2: A cycle with `en_wr` high loads `en_wdata` into the enable register, and `en_rdata` shows it after that clock edge. Bit 0 enables transfer complete, bit 1 enables transfer error and bit 2 enables port change.
- R3: A high bit on `sts_set` sets the matching status flag at the next edge. The flag then stays set without further pulses.
- R4: A cycle with `sts_clr_wr` high clears every status flag whose `sts_clr_data` bit is one. Flags whose data bit is zero keep their value.
- R5: When a set pulse and a clear write hit the same status flag in one cycle, the flag ends up set.
- R6: A source whose enable bit is zero never raises `irq`, whatever its status flag and the threshold tick do.
- R7: When the port-change flag and its enable are both set, `irq` is high one cycle later with no threshold tick needed.
- R8: A transfer-complete or transfer-error request that is enabled and pending does not raise `irq` until a cycle with `thr_tick` high. `irq` is high from the edge that samples that tick.
- R9: A captured deferred request holds `irq` high until its status flag or its enable bit is cleared. When no source is both enabled and pending, `irq` is low one cycle later.
- R10: A threshold tick in a cycle where a deferred source is not yet both enabled and pending is not remembered. The request waits for a later tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 3 | New enable value |
| en_rdata | output | 3 | Current enable value |
| sts_set | input | 3 | Event pulses from the controller, one per source |
| sts_clr_wr | input | 1 | Write strobe for write-one-to-clear of the status flags |
| sts_clr_data | input | 3 | Ones mark the status flags to clear |
| sts_rdata | output | 3 | Current status flags |
| thr_tick | input | 1 | Interrupt-threshold boundary pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench looks at four hazards:
- A tick that arrives in the same cycle as the event. A design that latched it would fire a deferred interrupt early.
- A clear write that collides with a set pulse. A design that let the clear win would lose an event.
- A clear write of zeros. A design that treated it as a plain write would wipe pending flags.
- The port change, which must fire without a tick. A design that gated it by the threshold would stall port notifications.

Further sequences drop the enable while a deferred request is held, and tick with every flag set but nothing enabled. A design that remembered a stale capture, or ignored the mask, would then leave `irq` stuck high.

// File: rtl/hig_pkg.sv
package hig_pkg;
   localparam int unsigned HIG_SRC_CMPL = 0;
   localparam int unsigned HIG_SRC_ERR  = 1;
   localparam int unsigned HIG_SRC_PORT = 2;
   localparam int unsigned HIG_NUM_SRC  = 3;
   localparam logic [HIG_NUM_SRC-1:0] HIG_IMM_DEFAULT = 3'b100;
endpackage

// File: rtl/hig_enable_reg.sv
module hig_enable_reg #(
   parameter int unsigned WIDTH = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST_VAL;
      else if (wr) q <= wdata;
   end
endmodule

// File: rtl/hig_status_reg.sv
module hig_status_reg #(
   parameter int unsigned WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set,
   input  logic             clr_wr,
   input  logic [WIDTH-1:0] clr_data,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] clr_mask;

   assign clr_mask = clr_data & {WIDTH{clr_wr}};

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          flag_q <= 1'b0;
         else if (set[i])     flag_q <= 1'b1;   // event wins over a clear
         else if (clr_mask[i]) flag_q <= 1'b0;
      end
      assign q[i] = flag_q;
   end
endmodule

// File: rtl/hig_src_gate.sv
module hig_src_gate #(
   parameter bit IMMEDIATE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pend,
   input  logic tick,
   output logic req_nxt
);
   logic active;

   assign active = en & pend;

   if (IMMEDIATE) begin : g_imm
      logic unused_tick;
      assign unused_tick = tick;
      assign req_nxt     = active;
   end else begin : g_defer
      logic cap_q;
      logic cap_d;
      always_comb begin
         if (!active) cap_d = 1'b0;
         else         cap_d = cap_q | tick;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) cap_q <= 1'b0;
         else        cap_q <= cap_d;
      end
      assign req_nxt = cap_d;
   end
endmodule

// File: rtl/host_irq_gate.sv
module host_irq_gate
   import hig_pkg::*;
#(
   parameter int unsigned NUM_SRC = HIG_NUM_SRC,
   parameter logic [NUM_SRC-1:0] IMM_MASK = HIG_IMM_DEFAULT,
   parameter logic [NUM_SRC-1:0] EN_RST = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_wdata,
   output logic [NUM_SRC-1:0] en_rdata,
   input  logic [NUM_SRC-1:0] sts_set,
   input  logic               sts_clr_wr,
   input  logic [NUM_SRC-1:0] sts_clr_data,
   output logic [NUM_SRC-1:0] sts_rdata,
   input  logic               thr_tick,
   output logic               irq
);
   localparam int unsigned NUM_DEFER = NUM_SRC - $countones(IMM_MASK);

   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_num_src
      $error("host_irq_gate: NUM_SRC must be within 1..32");
   end
   if (NUM_DEFER > NUM_SRC) begin : g_bad_mask
      $error("host_irq_gate: IMM_MASK inconsistent");
   end

   logic [NUM_SRC-1:0] req_nxt;
   logic               irq_q;

   hig_enable_reg #(.WIDTH(NUM_SRC), .RST_VAL(EN_RST)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (en_wr),
      .wdata (en_wdata),
      .q     (en_rdata)
   );

   hig_status_reg #(.WIDTH(NUM_SRC)) u_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (sts_set),
      .clr_wr   (sts_clr_wr),
      .clr_data (sts_clr_data),
      .q        (sts_rdata)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      hig_src_gate #(.IMMEDIATE(IMM_MASK[s])) u_gate (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (en_rdata[s]),
         .pend    (sts_rdata[s]),
         .tick    (thr_tick),
         .req_nxt (req_nxt[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |req_nxt;
   end

   assign irq = irq_q;
endmodule

// File: rtl/hig_checker.sv
module hig_checker #(
   parameter int unsigned NUM_SRC = 3,
   parameter logic [NUM_SRC-1:0] IMM_MASK = 3'b100
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_wr,
   input logic [NUM_SRC-1:0] en_wdata,
   input logic [NUM_SRC-1:0] en_rdata,
   input logic [NUM_SRC-1:0] sts_set,
   input logic               sts_clr_wr,
   input logic [NUM_SRC-1:0] sts_clr_data,
   input logic [NUM_SRC-1:0] sts_rdata,
   input logic               thr_tick,
   input logic               irq
);
   AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> en_rdata == $past(en_wdata));  // R2

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (|sts_set) |=> ((sts_rdata & $past(sts_set)) == $past(sts_set)));  // R3

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sts_clr_wr |=> ((sts_rdata & $past(sts_clr_data & ~sts_set)) == '0));  // R4

   AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      sts_clr_wr |=> (((sts_rdata ^ $past(sts_rdata)) & ~$past(sts_clr_data | sts_set)) == '0));  // R4

   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr_wr && (|(sts_set & sts_clr_data))) |=>
         ((sts_rdata & $past(sts_set & sts_clr_data)) == $past(sts_set & sts_clr_data)));  // R5

   AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|(en_rdata & sts_rdata)));  // R6

   AST_IMM_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(en_rdata & sts_rdata & IMM_MASK)) |=> irq);  // R7

   AST_DEFER_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq) && !$past(|(en_rdata & sts_rdata & IMM_MASK))) |-> $past(thr_tick));  // R8

   AST_DROP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(en_rdata & sts_rdata)) |=> !irq);  // R9
endmodule

bind host_irq_gate hig_checker #(.NUM_SRC(NUM_SRC), .IMM_MASK(IMM_MASK)) u_hig_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .en_wr        (en_wr),
   .en_wdata     (en_wdata),
   .en_rdata     (en_rdata),
   .sts_set      (sts_set),
   .sts_clr_wr   (sts_clr_wr),
   .sts_clr_data (sts_clr_data),
   .sts_rdata    (sts_rdata),
   .thr_tick     (thr_tick),
   .irq          (irq)
);

// File: tb/test_host_irq_gate.sv
module test_host_irq_gate;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_wr = 1'b0;
   logic [2:0] en_wdata = '0;
   logic [2:0] en_rdata;
   logic [2:0] sts_set = '0;
   logic       sts_clr_wr = 1'b0;
   logic [2:0] sts_clr_data = '0;
   logic [2:0] sts_rdata;
   logic       thr_tick = 1'b0;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic       irq;
      logic [2:0] sts;
      logic [2:0] en;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   // reference state, from the requirements
   logic [2:0] m_en = '0, m_sts = '0, m_cap = '0;
   logic       m_irq = 1'b0;

   always #2 clk = ~clk;

   host_irq_gate i_host_irq_gate (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
      .sts_set(sts_set), .sts_clr_wr(sts_clr_wr), .sts_clr_data(sts_clr_data),
      .sts_rdata(sts_rdata), .thr_tick(thr_tick), .irq(irq)
   );

   task automatic cyc(input logic [2:0] set, input logic cw, input logic [2:0] cd,
                      input logic ew, input logic [2:0] ed, input logic tk, input string tag);
      logic [2:0] n_en, n_sts, n_cap;
      exp_t e;
      @(negedge clk);
      sts_set = set; sts_clr_wr = cw; sts_clr_data = cd;
      en_wr = ew; en_wdata = ed; thr_tick = tk;
      n_en  = ew ? ed : m_en;
      n_sts = (m_sts & ~(cw ? cd : 3'b000)) | set;
      n_cap = '0;
      for (int i = 0; i < 2; i++)
         n_cap[i] = (m_en[i] & m_sts[i]) ? (m_cap[i] | tk) : 1'b0;
      m_irq = (m_en[2] & m_sts[2]) | (|n_cap);
      m_en = n_en; m_sts = n_sts; m_cap = n_cap;
      e.irq = m_irq; e.sts = m_sts; e.en = m_en; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(3'b000, 1'b0, 3'b000, 1'b0, 3'b000, 1'b0, tag);
   endtask

   // monitor: compares one expected item per clock edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (irq !== e.irq || sts_rdata !== e.sts || en_rdata !== e.en) begin
               n_fail++;
               $display("FAIL %s: irq=%b sts=%b en=%b expected irq=%b sts=%b en=%b",
                        e.tag, irq, sts_rdata, en_rdata, e.irq, e.sts, e.en);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      n_checks++;
      if (irq !== 1'b0 || sts_rdata !== 3'b000 || en_rdata !== 3'b000) begin
         n_fail++;
         $display("FAIL R1: irq=%b sts=%b en=%b expected 0 000 000", irq, sts_rdata, en_rdata);
      end
      idle(2, "R1");

      // R2 enable loads and reads back
      cyc(3'b000, 1'b0, 3'b000, 1'b1, 3'b101, 1'b0, "R2");
      cyc(3'b000, 1'b0, 3'b000, 1'b1, 3'b010, 1'b0, "R2");
      cyc(3'b000, 1'b0, 3'b000, 1'b1, 3'b000, 1'b0, "R2");

      // R3 sticky status with everything disabled (R6)
      cyc(3'b111, 1'b0, 3'b000, 1'b0, 3'b000, 1'b0, "R3");
      idle(2, "R3");
      cyc(3'b000, 1'b0, 3'b000, 1'b0, 3'b000, 1'b1, "R6");
      idle(2, "R6");

      // R4 write of zeros keeps, write of ones clears
      cyc(3'b000, 1'b1, 3'b000, 1'b0, 3'b000, 1'b0, "R4");
      cyc(3'b000, 1'b1, 3'b101, 1'b0, 3'b000, 1'b0, "R4");
      idle(1, "R4");

      // R5 set and clear of bit 1 collide, then bit 0 set while bit 1 cleared
      cyc(3'b010, 1'b1, 3'b010, 1'b0, 3'b000, 1'b0, "R5");
      cyc(3'b001, 1'b1, 3'b011, 1'b0, 3'b000, 1'b0, "R5");
      cyc(3'b000, 1'b1, 3'b111, 1'b0, 3'b000, 1'b0, "R4");

      // R7 port change fires without tick
      cyc(3'b000, 1'b0, 3'b000, 1'b1, 3'b100, 1'b0, "R7");
      cyc(3'b100, 1'b0, 3'b000, 1'b0, 3'b000, 1'b0, "R7");
      idle(3, "R7");
      cyc(3'b000, 1'b1, 3'b100, 1'b0, 3'b000, 1'b0, "R9");
      idle(2, "R9");

      // R8 transfer complete waits for tick
      cyc(3'b000, 1'b0, 3'b000, 1'b1, 3'b011, 1'b0, "R8");
      cyc(3'b001, 1'b0, 3'b000, 1'b0, 3'b000, 1'b0, "R8");
      idle(4, "R8");
      cyc(3'b000, 1'b0, 3'b000, 1'b0, 3'b000, 1'b1, "R8");
      idle(3, "R9");
      cyc(3'b000, 1'b1, 3'b001, 1'b0, 3'b000, 1'b0, "R9");
      idle(2, "R9");

      // R10 tick together with the event is not remembered (error source)
      cyc(3'b010, 1'b0, 3'b000, 1'b0, 3'b000, 1'b1, "R10");
      idle(3, "R10");
      cyc(3'b000, 1'b0, 3'b000, 1'b0, 3'b000, 1'b1, "R10");
      idle(2, "R9");
      // dropping the enable releases the held request
      cyc(3'b000, 1'b0, 3'b000, 1'b1, 3'b001, 1'b0, "R9");
      idle(2, "R9");
      // re-enable: earlier capture must not come back without a new tick
      cyc(3'b000, 1'b0, 3'b000, 1'b1, 3'b011, 1'b0, "R10");
      idle(2, "R10");
      cyc(3'b000, 1'b0, 3'b000, 1'b0, 3'b000, 1'b1, "R8");
      // port change joins, then deferred cleared: irq stays via port change
      cyc(3'b000, 1'b0, 3'b000, 1'b1, 3'b111, 1'b0, "R7");
      cyc(3'b100, 1'b1, 3'b010, 1'b0, 3'b000, 1'b0, "R7");
      idle(2, "R7");
      cyc(3'b000, 1'b1, 3'b100, 1'b0, 3'b000, 1'b0, "R9");
      idle(3, "R9");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule